// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block supervises one 10BASE-T twisted-pair link from the digital side. It requests a normal link pulse whenever the transmitter has been quiet for one pulse period. It runs a link-loss timer that every received packet or link pulse restarts. If the timer runs out, a link-pass flag drops, and the transmit path uses that flag to hold back packets. Link pulses keep being requested while the link is failed. Two events bring the link back up: one received packet, or two received link pulses with a gap that falls inside a timed window.

The block also judges the polarity of the receive pair. It combines the polarity of received link pulses with the line level seen after each received frame's end-of-frame sequence. When the reversed-pair evidence is complete, a sticky flag is raised. A configuration input decides whether that flag is turned into a swap command for the receive path.

Event inputs are single-cycle strobes from the receive decoder and the transmit encoder. All timing is counted in cycles of the block clock, and the defaults assume 10 MHz: a 16 ms pulse period, a 64 ms link-loss timeout and a requalification window whose gap must be above 6 ms and at most 50 ms.

Top module: `link_integrity_mon`

## Requirements
- R1: After reset, link_pass_o, lp_req_o, pol_rev_o and pol_swap_o are all 0, so the link starts failed and the polarity starts as normal.
- R2: With tx_busy_i and tx_eof_i low, lp_req_o pulses high for exactly one cycle every LP_PERIOD cycles. The first pulse is visible LP_PERIOD cycles after the first clock edge following reset release.
- R3: A cycle that samples tx_eof_i or tx_busy_i high restarts the pulse timer, and no pulse is requested in such a cycle. The next pulse comes LP_PERIOD cycles after the last such cycle.
- R4: Link pulses are requested while link_pass_o is 0.
- R5: While the link is failed, a sampled rx_pkt_i raises link_pass_o on that same edge.
- R6: While the link is failed, two rx_lp_i strobes sampled more than REQ_MIN_GAP and at most REQ_MAX_GAP cycles apart raise link_pass_o on the edge that samples the second strobe. A single strobe does not raise it.
- R7: A second rx_lp_i strobe at REQ_MIN_GAP cycles or less after the first does not qualify the link. It restarts the window, so the gap to any later pulse is measured from this strobe.
- R8: If REQ_MAX_GAP cycles pass after a first pulse with no second pulse, the window closes. The next pulse then opens a new window.
- R9: While link_pass_o is 1, it falls exactly LOSS_CYC cycles after the last sampled rx_pkt_i or rx_lp_i. Each such strobe restarts the count.
- R10: pol_rev_o rises on the edge where both of these have become true, in either order: at least one rx_lp_i strobe with rx_lp_rev_i high has been seen, and the last NEG_FRAMES rx_eof_i strobes all had rx_eof_neg_i high. An rx_eof_i strobe with rx_eof_neg_i low resets the run of negative frames. Once set, pol_rev_o stays set until reset.
- R11: pol_swap_o is 1 exactly when pol_rev_o is 1 and auto_fix_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (10 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_busy_i | input | 1 | Transmitter is sending a packet |
| tx_eof_i | input | 1 | Strobe: transmitted end-of-frame sequence completed |
| rx_pkt_i | input | 1 | Strobe: a packet was received |
| rx_lp_i | input | 1 | Strobe: a normal link pulse was received |
| rx_lp_rev_i | input | 1 | Polarity of the received link pulse was reversed (valid with rx_lp_i) |
| rx_eof_i | input | 1 | Strobe: a received frame ended |
| rx_eof_neg_i | input | 1 | Line level after that end-of-frame was negative (valid with rx_eof_i) |
| auto_fix_en_i | input | 1 | Allow automatic correction of a reversed pair |
| link_pass_o | output | 1 | Link is up; packet transmission is allowed |
| lp_req_o | output | 1 | One-cycle request to send a link pulse |
| pol_rev_o | output | 1 | Receive pair has been judged reversed |
| pol_swap_o | output | 1 | Command to invert receive polarity |

## Verification
The pulse generator is first run with the transmitter idle, which shows the free-running period and the single-cycle width. A transmit end-of-frame strobe is then placed in the middle of a period; this separates a timer that restarts from one that keeps its phase. A long busy stretch follows, and the busy stretch separates suppression from mere restart. Requalification is driven with pulse gaps one cycle above the minimum, equal to the minimum, a short gap after a restart that would count if measured from the first pulse, one cycle past the maximum, and exactly the maximum. Each of these lands on one side of a window edge. Polarity is tried with a run of negative frames broken by one positive frame, with the reversed pulse before the frames and after them, and with the correction enable in both settings.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic [1:0] {
    LNK_FAIL  = 2'd0,
    LNK_ARMED = 2'd1,
    LNK_PASS  = 2'd2
  } link_st_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lim_lp_gen.sv
module lim_lp_gen #(
  parameter int unsigned PERIOD = 160000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_busy_i,
  input  logic tx_eof_i,
  output logic lp_req_o
);
  localparam int unsigned W = lim_pkg::cnt_w(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;
  logic         req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (tx_busy_i || tx_eof_i) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        req_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign lp_req_o = req_q;
endmodule

// File: rtl/lim_link_fsm.sv
module lim_link_fsm #(
  parameter int unsigned LOSS_CYC    = 640000,
  parameter int unsigned REQ_MIN_GAP = 60000,
  parameter int unsigned REQ_MAX_GAP = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_pkt_i,
  input  logic rx_lp_i,
  output logic link_pass_o
);
  import lim_pkg::*;

  localparam int unsigned SPAN = (LOSS_CYC > REQ_MAX_GAP) ? LOSS_CYC : REQ_MAX_GAP;
  localparam int unsigned W    = cnt_w(SPAN);
  localparam logic [W-1:0] LOSS_LAST = W'(LOSS_CYC - 1);
  localparam logic [W-1:0] WIN_LAST  = W'(REQ_MAX_GAP - 1);
  localparam logic [W-1:0] GAP_MIN   = W'(REQ_MIN_GAP);

  link_st_e     st_q, st_d;
  logic [W-1:0] tmr_q, tmr_d;

  // one timer: gap since first pulse while armed, idle time while passing
  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    unique case (st_q)
      LNK_FAIL: begin
        tmr_d = '0;
        if (rx_pkt_i)     st_d = LNK_PASS;
        else if (rx_lp_i) st_d = LNK_ARMED;
      end
      LNK_ARMED: begin
        if (rx_pkt_i) begin
          st_d  = LNK_PASS;
          tmr_d = '0;
        end else if (rx_lp_i) begin
          tmr_d = '0;
          // elapsed gap is tmr_q+1; too early restarts the window
          if (tmr_q >= GAP_MIN) st_d = LNK_PASS;
        end else if (tmr_q == WIN_LAST) begin
          st_d  = LNK_FAIL;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + W'(1);
        end
      end
      LNK_PASS: begin
        if (rx_pkt_i || rx_lp_i) begin
          tmr_d = '0;
        end else if (tmr_q == LOSS_LAST) begin
          st_d  = LNK_FAIL;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + W'(1);
        end
      end
      default: begin
        st_d  = LNK_FAIL;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LNK_FAIL;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign link_pass_o = (st_q == LNK_PASS);
endmodule

// File: rtl/lim_pol_det.sv
module lim_pol_det #(
  parameter int unsigned NEG_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_lp_i,
  input  logic rx_lp_rev_i,
  input  logic rx_eof_i,
  input  logic rx_eof_neg_i,
  output logic pol_rev_o
);
  localparam int unsigned RW = $clog2(NEG_FRAMES + 1);
  localparam logic [RW-1:0] TGT = RW'(NEG_FRAMES);

  logic          seen_q, seen_d;
  logic [RW-1:0] run_q, run_d;
  logic          rev_q, rev_d;

  always_comb begin
    seen_d = seen_q | (rx_lp_i & rx_lp_rev_i);
    run_d  = run_q;
    if (rx_eof_i) begin
      if (!rx_eof_neg_i)    run_d = '0;
      else if (run_q != TGT) run_d = run_q + RW'(1);
    end
    rev_d = rev_q | (seen_d & (run_d == TGT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      run_q  <= '0;
      rev_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      run_q  <= run_d;
      rev_q  <= rev_d;
    end
  end

  assign pol_rev_o = rev_q;
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int unsigned LP_PERIOD   = 160000,
  parameter int unsigned LOSS_CYC    = 640000,
  parameter int unsigned REQ_MIN_GAP = 60000,
  parameter int unsigned REQ_MAX_GAP = 500000,
  parameter int unsigned NEG_FRAMES  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_busy_i,
  input  logic tx_eof_i,
  input  logic rx_pkt_i,
  input  logic rx_lp_i,
  input  logic rx_lp_rev_i,
  input  logic rx_eof_i,
  input  logic rx_eof_neg_i,
  input  logic auto_fix_en_i,
  output logic link_pass_o,
  output logic lp_req_o,
  output logic pol_rev_o,
  output logic pol_swap_o
);
  logic pol_rev;

  lim_lp_gen #(.PERIOD(LP_PERIOD)) u_lp_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_busy_i (tx_busy_i),
    .tx_eof_i  (tx_eof_i),
    .lp_req_o  (lp_req_o)
  );

  lim_link_fsm #(
    .LOSS_CYC    (LOSS_CYC),
    .REQ_MIN_GAP (REQ_MIN_GAP),
    .REQ_MAX_GAP (REQ_MAX_GAP)
  ) u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_pkt_i    (rx_pkt_i),
    .rx_lp_i     (rx_lp_i),
    .link_pass_o (link_pass_o)
  );

  lim_pol_det #(.NEG_FRAMES(NEG_FRAMES)) u_pol (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_lp_i      (rx_lp_i),
    .rx_lp_rev_i  (rx_lp_rev_i),
    .rx_eof_i     (rx_eof_i),
    .rx_eof_neg_i (rx_eof_neg_i),
    .pol_rev_o    (pol_rev)
  );

  assign pol_rev_o  = pol_rev;
  assign pol_swap_o = pol_rev & auto_fix_en_i;
endmodule

// File: rtl/lim_chk.sv
module lim_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_busy_i,
  input logic tx_eof_i,
  input logic rx_pkt_i,
  input logic rx_lp_i,
  input logic rx_eof_i,
  input logic link_pass_o,
  input logic lp_req_o,
  input logic pol_rev_o,
  input logic pol_swap_o
);
  // R5 R6
  link_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_pass_o) |-> $past(rx_pkt_i || rx_lp_i));

  // R9
  link_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_pass_o) |-> !$past(rx_pkt_i || rx_lp_i));

  // R2
  lp_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_req_o |=> !lp_req_o);

  // R3
  lp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_req_o |-> (!$past(tx_busy_i) && !$past(tx_eof_i)));

  // R10
  pol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_rev_o |=> pol_rev_o);

  // R10
  pol_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pol_rev_o) |-> $past(rx_eof_i || rx_lp_i));

  // R11
  pol_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_swap_o |-> pol_rev_o);
endmodule

bind link_integrity_mon lim_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_busy_i   (tx_busy_i),
  .tx_eof_i    (tx_eof_i),
  .rx_pkt_i    (rx_pkt_i),
  .rx_lp_i     (rx_lp_i),
  .rx_eof_i    (rx_eof_i),
  .link_pass_o (link_pass_o),
  .lp_req_o    (lp_req_o),
  .pol_rev_o   (pol_rev_o),
  .pol_swap_o  (pol_swap_o)
);

// File: tb/link_integrity_mon_tb_top.sv
module link_integrity_mon_tb_top;
  localparam int P    = 80;
  localparam int LOSS = 320;
  localparam int GMIN = 30;
  localparam int GMAX = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_busy = 1'b0, tx_eof = 1'b0, rx_pkt = 1'b0, rx_lp = 1'b0, rx_lp_rev = 1'b0;
  logic rx_eof = 1'b0, rx_eof_neg = 1'b0, fix_en = 1'b0;
  logic link_pass, lp_req, pol_rev, pol_swap;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  link_integrity_mon #(
    .LP_PERIOD(P), .LOSS_CYC(LOSS), .REQ_MIN_GAP(GMIN), .REQ_MAX_GAP(GMAX), .NEG_FRAMES(4)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_busy_i(tx_busy), .tx_eof_i(tx_eof),
    .rx_pkt_i(rx_pkt), .rx_lp_i(rx_lp), .rx_lp_rev_i(rx_lp_rev),
    .rx_eof_i(rx_eof), .rx_eof_neg_i(rx_eof_neg), .auto_fix_en_i(fix_en),
    .link_pass_o(link_pass), .lp_req_o(lp_req), .pol_rev_o(pol_rev), .pol_swap_o(pol_swap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // scoreboard monitor: every link pulse request must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && lp_req && !done) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(e == cyc, "R2/R3 pulse cycle", cyc, e);
      end
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic send_eof_tx();
    tx_eof = 1'b1; @(negedge clk); tx_eof = 1'b0;
  endtask

  task automatic send_pkt();
    rx_pkt = 1'b1; @(negedge clk); rx_pkt = 1'b0;
  endtask

  task automatic send_lp(input bit rev);
    rx_lp = 1'b1; rx_lp_rev = rev; @(negedge clk); rx_lp = 1'b0; rx_lp_rev = 1'b0;
  endtask

  task automatic send_fr(input bit neg);
    rx_eof = 1'b1; rx_eof_neg = neg; @(negedge clk); rx_eof = 1'b0; rx_eof_neg = 1'b0;
  endtask

  task automatic idle_out();
    int t;
    t = cyc;
    wait_cyc(t + LOSS + 2);
    chk(link_pass == 1'b0, "R9 timeout between cases", link_pass, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog at cycle %0d: actual hung expected done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int a, b, c;
    repeat (3) @(negedge clk);
    chk(link_pass == 0 && lp_req == 0 && pol_rev == 0 && pol_swap == 0, "R1 reset state",
        {link_pass, lp_req, pol_rev, pol_swap}, 0);
    rst_n = 1'b1;

    // R2 free-running pulses, R4 while link failed
    exp_q.push_back(P);
    exp_q.push_back(2 * P);
    wait_cyc(P);
    chk(lp_req == 1 && link_pass == 0, "R4 pulse while failed", {lp_req, link_pass}, 2);
    wait_cyc(170);
    // R3 end-of-frame restarts the timer mid-period
    send_eof_tx();
    exp_q.push_back(cyc + P);
    wait_cyc(3 * P);
    chk(lp_req == 0, "R3 old phase suppressed", lp_req, 0);
    wait_cyc(280);
    tx_busy = 1'b1;
    wait_cyc(400);
    tx_busy = 1'b0;
    exp_q.push_back(cyc + P);
    wait_cyc(400 + P + 5);
    tx_busy = 1'b1;

    // R5 packet requalifies, R9 restart and expiry
    send_pkt();
    chk(link_pass == 1, "R5 packet raises link", link_pass, 1);
    a = cyc;
    wait_cyc(a + 200);
    send_lp(1'b0);
    b = cyc;
    wait_cyc(b + LOSS - 1);
    chk(link_pass == 1, "R9 restarted by pulse", link_pass, 1);
    wait_cyc(b + LOSS);
    chk(link_pass == 0, "R9 expiry", link_pass, 0);

    // R6 gap just above minimum
    send_lp(1'b0);
    a = cyc;
    chk(link_pass == 0, "R6 single pulse", link_pass, 0);
    wait_cyc(a + GMIN);
    send_lp(1'b0);
    chk(link_pass == 1, "R6 valid gap", link_pass, 1);
    idle_out();

    // R7 gap equal to minimum restarts window
    send_lp(1'b0);
    a = cyc;
    wait_cyc(a + GMIN - 1);
    send_lp(1'b0);
    chk(link_pass == 0, "R7 gap equal min", link_pass, 0);
    b = cyc;
    wait_cyc(b + 19);
    send_lp(1'b0);
    chk(link_pass == 0, "R7 measured from restart", link_pass, 0);
    c = cyc;
    wait_cyc(c + GMIN);
    send_lp(1'b0);
    chk(link_pass == 1, "R7 qualify after restart", link_pass, 1);
    idle_out();

    // R8 window closes; exact maximum qualifies
    send_lp(1'b0);
    a = cyc;
    wait_cyc(a + GMAX);
    send_lp(1'b0);
    chk(link_pass == 0, "R8 late pulse", link_pass, 0);
    b = cyc;
    wait_cyc(b + GMAX - 1);
    send_lp(1'b0);
    chk(link_pass == 1, "R8 gap equal max", link_pass, 1);
    idle_out();

    // R10 reversed pulse first, broken run
    send_lp(1'b1);
    for (int i = 0; i < 3; i++) send_fr(1'b1);
    send_fr(1'b0);
    for (int i = 0; i < 3; i++) send_fr(1'b1);
    chk(pol_rev == 0, "R10 broken run", pol_rev, 0);
    send_fr(1'b1);
    chk(pol_rev == 1, "R10 declared", pol_rev, 1);
    chk(pol_swap == 0, "R11 correction disabled", pol_swap, 0);
    fix_en = 1'b1;
    #1;
    chk(pol_swap == 1, "R11 correction enabled", pol_swap, 1);
    @(negedge clk);

    // R1 again, then R10 with frames first
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(pol_rev == 0 && pol_swap == 0 && link_pass == 0, "R1 reset clears", {pol_rev, pol_swap, link_pass}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) send_fr(1'b1);
    chk(pol_rev == 0, "R10 no reversed pulse", pol_rev, 0);
    send_lp(1'b0);
    chk(pol_rev == 0, "R10 normal pulse", pol_rev, 0);
    send_lp(1'b1);
    chk(pol_rev == 1, "R10 pulse after frames", pol_rev, 1);
    repeat (3) @(negedge clk);
    chk(pol_rev == 1, "R10 sticky", pol_rev, 1);

    chk(exp_q.size() == 0, "R2 all expected pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule